// File: doc/BRIEF.md
# Zero-Run Encoder with Byte Packer

This block sits at the front of a feature-map compressor. It accepts one 8-bit word per cycle over a valid/ready handshake. For each word it emits a short variable-length code that says whether the word was zero. Runs of consecutive zeros collapse into a single 5-bit symbol, and each non-zero word costs one bit. A packer collects these symbols and turns them into 8-bit words for a memory bus. A downstream value compressor needs the non-zero words, so each one is also copied to a side port.

A flush request ends the current stream. It closes any open zero run and pads the last partial output byte with zeros. It also marks the final output beat, so the stream can be stored and decoded as one unit. Bits are packed LSB-first. Bit 0 of an output byte is the earliest bit of the stream, and each new symbol is placed above the bits that are already waiting.

Top module: `zrle_encoder`

## Requirements
- R1: An accepted non-zero word with no zero run open adds exactly one bit, of value 1, to the bit stream.
- R2: A run of N zeros (1 ≤ N ≤ 16) is encoded as a 0 flag bit followed by a 4-bit field holding N−1, sent least significant bit first. The whole symbol is 5 bits.
- R3: When a run reaches 16 zeros, its symbol (field 15) is emitted at once and the count restarts. Any further zeros form a new run, encoded in a later symbol.
- R4: A non-zero word that arrives while a zero run is open first closes that run: the run's 5-bit symbol goes into the stream, then the 1 bit for the word.
- R5: Stream bits are packed LSB-first into 8-bit output words, in stream order. A full output word is offered as soon as at least 8 bits are waiting.
- R6: When flush is accepted (flush high while in_ready is high), the block does these things in order:
  - It first encodes any word accepted in the same cycle, then closes the open run.
  - It pads the remaining partial byte with zeros above the valid bits.
  - It raises out_last on the beat that carries the final stream bit. If every bit has already been sent, no extra beat is produced.
  - It holds in_ready low until that last beat has been taken.
- R7: The cycle after a non-zero word is accepted, nz_valid is high for exactly one cycle and nz_data holds that word. Zero words never appear on this port. The port has no backpressure.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable. in_ready is low whenever the packer could not take a worst-case 6-bit symbol in this cycle.
- R9: After reset, in_ready is high, out_valid and nz_valid are low, and no zero run is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word or flush this cycle |
| in_data | input | 8 | Input word |
| flush | input | 1 | End-of-stream request, accepted when in_ready is high |
| out_valid | output | 1 | Packed output word present |
| out_ready | input | 1 | Consumer takes the packed word |
| out_data | output | 8 | Packed bits, bit 0 earliest |
| out_last | output | 1 | Beat holds the final bit of a flushed stream |
| nz_valid | output | 1 | Non-zero word forwarded this cycle |
| nz_data | output | 8 | Forwarded non-zero word |

## Verification
The bench aims at the following boundaries:
- Runs of exactly 16 and 17 zeros. An off-by-one at saturation would emit a length field of 0 for the 16-zero case, or lose the leftover zero.
- A flush issued in the same cycle as a zero or non-zero word. If the order were wrong, the word would be dropped or would land after the padding.
- A flush when the bit count is already a multiple of 8. A wrong design would invent a spurious all-zero beat, or leave out_last off.
- Random output stalls. These expose data that changes under backpressure, or symbols lost when the accumulator nears full.

// File: rtl/zrle_pkg.sv
`timescale 1ns/1ps
package zrle_pkg;
    localparam int WORD_W    = 8;
    localparam int OUT_W     = 8;
    localparam int MAX_RUN   = 16;
    localparam int LEN_W     = $clog2(MAX_RUN);
    localparam int RUN_SYM_W = LEN_W + 1;
    localparam int SYM_W     = RUN_SYM_W + 1;
    localparam int ACC_W     = 2 * OUT_W;
    localparam int FILL_W    = $clog2(ACC_W + 1);
    localparam int SLEN_W    = $clog2(SYM_W + 1);
    localparam int CNT_W     = $clog2(MAX_RUN + 1);

    typedef logic [SYM_W-1:0] sym_bits_t;

    typedef struct packed {
        sym_bits_t         bits;
        logic [SLEN_W-1:0] len;
    } sym_t;

    // Zero-run symbol: flag 0 in bit 0, (count-1) above it.
    function automatic sym_bits_t run_code(input logic [CNT_W-1:0] n);
        logic [CNT_W-1:0] f;
        f = n - CNT_W'(1);
        return sym_bits_t'({f[LEN_W-1:0], 1'b0});
    endfunction
endpackage

// File: rtl/zrle_symgen.sv
`timescale 1ns/1ps
module zrle_symgen
    import zrle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_fire,
    input  logic [WORD_W-1:0] word,
    input  logic              flush_fire,
    output sym_t              sym
);
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_nxt;
    logic [CNT_W-1:0] cnt_inc;
    logic             is_zero;

    always_comb begin
        is_zero = ~|word;
        cnt_inc = run_cnt + CNT_W'(1);
        sym     = '0;
        run_nxt = run_cnt;
        if (word_fire) begin
            if (is_zero) begin
                if (cnt_inc == CNT_W'(MAX_RUN) || flush_fire) begin
                    sym.bits = run_code(cnt_inc);
                    sym.len  = SLEN_W'(RUN_SYM_W);
                    run_nxt  = '0;
                end else begin
                    run_nxt  = cnt_inc;
                end
            end else begin
                if (run_cnt != '0) begin
                    sym.bits = run_code(run_cnt) | (sym_bits_t'(1) << RUN_SYM_W);
                    sym.len  = SLEN_W'(RUN_SYM_W + 1);
                end else begin
                    sym.bits = sym_bits_t'(1);
                    sym.len  = SLEN_W'(1);
                end
                run_nxt = '0;
            end
        end else if (flush_fire && run_cnt != '0) begin
            sym.bits = run_code(run_cnt);
            sym.len  = SLEN_W'(RUN_SYM_W);
            run_nxt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else     run_cnt <= run_nxt;
    end

    // R3: an open run never holds the saturation count
    assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run_cnt < CNT_W'(MAX_RUN));
endmodule

// File: rtl/zrle_side.sv
`timescale 1ns/1ps
module zrle_side
    import zrle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_fire,
    input  logic [WORD_W-1:0] word,
    output logic              nz_valid,
    output logic [WORD_W-1:0] nz_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nz_valid <= 1'b0;
            nz_data  <= '0;
        end else begin
            nz_valid <= word_fire && (|word);
            if (word_fire) nz_data <= word;
        end
    end

    // R7: forwarded words are never zero
    assert_nz_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        nz_valid |-> (nz_data != '0));
endmodule

// File: rtl/zrle_packer.sv
`timescale 1ns/1ps
module zrle_packer
    import zrle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sym_t             sym,
    input  logic             flush_fire,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic             room
);
    logic [ACC_W-1:0]  acc, acc_nxt;
    logic [FILL_W-1:0] fill, fill_nxt, take, rem;
    logic              flush_pend;

    always_comb begin
        out_valid = (fill >= FILL_W'(OUT_W)) || (flush_pend && fill != '0);
        out_last  = flush_pend && fill != '0 && fill <= FILL_W'(OUT_W);
        out_data  = acc[OUT_W-1:0];
        take      = '0;
        if (out_valid && out_ready)
            take = (fill >= FILL_W'(OUT_W)) ? FILL_W'(OUT_W) : fill;
        rem      = fill - take;
        room     = !flush_pend && (rem <= FILL_W'(ACC_W - SYM_W));
        acc_nxt  = (acc >> take) | (ACC_W'(sym.bits) << rem);
        fill_nxt = rem + FILL_W'(sym.len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            fill       <= '0;
            flush_pend <= 1'b0;
        end else begin
            acc  <= acc_nxt;
            fill <= fill_nxt;
            if (flush_fire)
                flush_pend <= 1'b1;
            else if (flush_pend && (fill == '0 || (out_last && out_ready)))
                flush_pend <= 1'b0;
        end
    end

    // R8: a stalled beat stays offered and unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: admission keeps the accumulator within its width
    assert_fill_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(ACC_W));

    // R6: after the last beat nothing remains to send
    assert_last_drains_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && out_ready) |=> !out_valid);
endmodule

// File: rtl/zrle_encoder.sv
`timescale 1ns/1ps
module zrle_encoder
    import zrle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_last,
    output logic              nz_valid,
    output logic [WORD_W-1:0] nz_data
);
    logic room;
    logic word_fire;
    logic flush_fire;
    sym_t sym;

    assign in_ready   = room;
    assign word_fire  = in_valid && room;
    assign flush_fire = flush && room;

    zrle_symgen u_symgen (
        .clk        (clk),
        .rst        (rst),
        .word_fire  (word_fire),
        .word       (in_data),
        .flush_fire (flush_fire),
        .sym        (sym)
    );

    zrle_packer u_packer (
        .clk        (clk),
        .rst        (rst),
        .sym        (sym),
        .flush_fire (flush_fire),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .room       (room)
    );

    zrle_side u_side (
        .clk       (clk),
        .rst       (rst),
        .word_fire (word_fire),
        .word      (in_data),
        .nz_valid  (nz_valid),
        .nz_data   (nz_data)
    );
endmodule

// File: tb/zrle_encoder_tb_top.sv
`timescale 1ns/1ps
module zrle_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       flush = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;
    logic       nz_valid;
    logic [7:0] nz_data;

    always #2.5 clk = ~clk;

    zrle_encoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .flush(flush), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .nz_valid(nz_valid), .nz_data(nz_data)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R9";
    int    bp_mode  = 0;
    bit    done     = 1'b0;

    // behavioural reference state
    logic [7:0] exp_byte[$];
    bit         exp_last[$];
    logic [7:0] pbits = 8'h00;
    int         pcnt = 0;
    int         run_len = 0;
    bit         flushing = 1'b0;
    bit         exp_nz = 1'b0;
    logic [7:0] exp_nz_data = 8'h00;
    logic [7:0] b;
    bit         l;

    function automatic void check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endfunction

    function automatic void push_bit(bit v);
        pbits[pcnt] = v;
        pcnt++;
        if (pcnt == 8) begin
            exp_byte.push_back(pbits);
            exp_last.push_back(1'b0);
            pcnt  = 0;
            pbits = 8'h00;
        end
    endfunction

    // R2: flag 0 then (n-1) LSB first
    function automatic void push_run(int n);
        push_bit(1'b0);
        for (int i = 0; i < 4; i++) push_bit(bit'(((n - 1) >> i) & 1));
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            // R7: side port one cycle after acceptance
            check(nz_valid == exp_nz, "R7", "nz_valid", nz_valid, exp_nz);
            if (exp_nz && nz_valid)
                check(nz_data == exp_nz_data, "R7", "nz_data", nz_data, exp_nz_data);
            exp_nz = 1'b0;
            // R6: input blocked until the last beat leaves
            if (flushing) check(!in_ready, "R6", "in_ready during flush", in_ready, 0);
            if (out_valid && out_ready) begin
                if (exp_byte.size() == 0) begin
                    check(1'b0, phase, "unexpected beat", out_data, 0);
                end else begin
                    b = exp_byte.pop_front();
                    l = exp_last.pop_front();
                    check(out_data == b, phase, "out_data", out_data, b);
                    check(out_last == l, "R6", "out_last", out_last, l);
                    if (l) flushing = 1'b0;
                end
            end
            if (in_valid && in_ready) begin
                if (in_data == 8'h00) begin
                    run_len++;
                    if (run_len == 16 || flush) begin   // R3 saturation
                        push_run(run_len);
                        run_len = 0;
                    end
                end else begin
                    if (run_len > 0) push_run(run_len); // R4 close first
                    run_len = 0;
                    push_bit(1'b1);                     // R1
                    exp_nz      = 1'b1;
                    exp_nz_data = in_data;
                end
            end
            if (flush && in_ready) begin
                if (run_len > 0) push_run(run_len);
                run_len = 0;
                if (pcnt > 0) begin
                    do push_bit(1'b0); while (pcnt != 0);
                    exp_last[exp_last.size() - 1] = 1'b1;
                    flushing = 1'b1;
                end else if (exp_byte.size() > 0) begin
                    exp_last[exp_last.size() - 1] = 1'b1;
                    flushing = 1'b1;
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (bp_mode == 1)      out_ready = ($urandom_range(0, 2) != 0);
            else if (bp_mode == 2) out_ready = ($urandom_range(0, 5) == 0);
            else                   out_ready = 1'b1;
        end
    end

    task automatic send(input logic [7:0] w, input bit fl, input bit val);
        bit f;
        in_valid = val;
        in_data  = w;
        flush    = fl;
        do begin
            @(negedge clk);
            f = in_ready;
            @(posedge clk);
            #1;
        end while (!f);
        in_valid = 1'b0;
        flush    = 1'b0;
        in_data  = 8'h00;
    endtask

    task automatic drain();
        for (int k = 0; k < 400 && (flushing || exp_byte.size() != 0); k++) @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [7:0] rnd_word();
        if ($urandom_range(0, 9) < 4) return 8'h00;
        return 8'($urandom_range(1, 255));
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R9", "out_valid", out_valid, 0);
        check(nz_valid == 1'b0, "R9", "nz_valid", nz_valid, 0);
        @(posedge clk); #1;

        phase = "R1";
        for (int i = 1; i <= 16; i++) send(8'(i), 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0);
        drain();

        phase = "R2";
        for (int i = 0; i < 3; i++) send(8'h00, 1'b0, 1'b1);
        send(8'h5A, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) send(8'h00, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0);
        drain();

        phase = "R3";
        for (int i = 0; i < 16; i++) send(8'h00, 1'b0, 1'b1);
        send(8'h01, 1'b0, 1'b1);
        for (int i = 0; i < 17; i++) send(8'h00, 1'b0, 1'b1);
        send(8'h02, 1'b0, 1'b1);
        for (int i = 0; i < 32; i++) send(8'h00, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0);
        drain();

        phase = "R4";
        for (int i = 0; i < 10; i++) begin
            send(8'h00, 1'b0, 1'b1);
            send(8'(8'h80 + i), 1'b0, 1'b1);
        end
        send(8'h00, 1'b1, 1'b0);
        drain();

        phase = "R6";
        send(8'h00, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b1);   // zero word together with flush
        drain();
        send(8'h00, 1'b0, 1'b1);
        send(8'h33, 1'b1, 1'b1);   // non-zero word together with flush
        drain();
        for (int i = 0; i < 8; i++) send(8'h11, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0);   // exact byte boundary
        drain();
        send(8'h00, 1'b1, 1'b0);   // nothing pending
        drain();

        phase = "R5";
        for (int i = 0; i < 400; i++) begin
            send(rnd_word(), ($urandom_range(0, 49) == 0), 1'b1);
            if ($urandom_range(0, 19) == 0)
                for (int j = 0; j < int'($urandom_range(10, 40)); j++) send(8'h00, 1'b0, 1'b1);
        end
        send(8'h00, 1'b1, 1'b0);
        drain();

        phase = "R8";
        bp_mode = 1;
        for (int i = 0; i < 400; i++) send(rnd_word(), ($urandom_range(0, 59) == 0), 1'b1);
        bp_mode = 2;
        for (int i = 0; i < 200; i++) send(8'($urandom_range(1, 255)), 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0);
        drain();
        bp_mode = 0;
        drain();
        check(exp_byte.size() == 0, "R6", "bytes left after final flush", exp_byte.size(), 0);
        check(!flushing, "R6", "last beat seen", flushing, 0);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog: actual running expected finished");
            report();
        end
    end
endmodule